// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the pending state for one bank of 32 interrupts whose IDs start at a base that is a multiple of 32. Each interrupt is set to edge or level trigger by a per-bit mode register. The block takes the raw interrupt lines, write-one set-pending and clear-pending strobes, and per-interrupt activation pulses. It keeps one pending latch per interrupt.

The block offers two read views of pending state. The visible view is what a guest reads from its pending register. For level-triggered interrupts it is the latch ORed with the live line level. The latch view returns only the latch, so a save/restore agent can read it and load it back. A third view holds the sampled line level of every interrupt, and a restore agent can overwrite it. A restored level holds until the line of that interrupt next changes.

Interrupt lines pass through a synchronizer of `SYNC_STAGES` flops before edge detection. Interrupt IDs at or above `NUM_IRQ` do not exist. IDs 0 to 15 are software-generated and have no line.

Top module: `irq_pend_tracker`

## Requirements
- R1: After reset, `trig_cfg`, `pend_vis`, `pend_lat` and `line_lvl` are all zero.
- R2: An edge-mode interrupt sets its latch on a rising edge of its synchronized line, or when its bit is 1 in a `set_we` write. A set-pending write sets the latch in either trigger mode.
- R3: An edge-mode latch clears only when the interrupt's `act_pulse` bit is high or its bit is 1 in a `clr_we` write. For edge-mode bits, `pend_vis` equals `pend_lat`.
- R4: In level mode, a line level never sets the latch. For level-mode bits, `pend_vis` is `pend_lat` OR `line_lvl`.
- R5: In level mode, a clear write or an activation clears the latch, but `pend_vis` stays 1 while the line is high. `pend_vis` drops when the line goes low unless a set write has set the latch.
- R6: Writes act only on bits that are 1, and 0 bits leave state unchanged. When set and clear (or activation) hit a bit in the same cycle, set wins. A rising edge on an edge-mode bit in the same cycle as its clear or activation leaves the latch at 1.
- R7: A `lat_we` write loads `pend_lat` with the write data, limited to implemented bits. It overrides a set, clear or activation in the same cycle.
- R8: Bit n of `line_lvl` is the level of interrupt base+n, and 1 means asserted. A `lvl_we` write loads it, and in the same cycle it overrides a change on the input. The loaded value holds for each bit until that bit's synchronized input next changes, and the bit then follows the input.
- R9: Bits whose ID is at or above `NUM_IRQ` read 0 in all four outputs, and writes to them are ignored.
- R10: IDs 0 to 15 read 0 in `line_lvl` and ignore `lvl_we` data and their input lines. A set-pending write can still set their latch.
- R11: `trig_cfg` bit = 1 selects edge mode and 0 selects level mode. A `cfg_we` write stores the data limited to implemented bits. A mode change leaves `pend_lat` unchanged.
- R12: Every write takes effect on the clock edge that samples it. An input change reaches `line_lvl` and `pend_lat` on the (SYNC_STAGES+1)-th edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw interrupt lines, bit n = ID base+n |
| cfg_we | input | 1 | Trigger mode register write strobe |
| cfg_wdata | input | 32 | Trigger modes, 1 = edge |
| set_we | input | 1 | Set-pending write strobe |
| set_data | input | 32 | Set-pending bits (write 1 to set) |
| clr_we | input | 1 | Clear-pending write strobe |
| clr_data | input | 32 | Clear-pending bits (write 1 to clear) |
| act_pulse | input | 32 | Per-interrupt activation pulse |
| lat_we | input | 1 | Latch restore write strobe |
| lat_wdata | input | 32 | Latch restore data |
| lvl_we | input | 1 | Line level restore write strobe |
| lvl_wdata | input | 32 | Line level restore data |
| trig_cfg | output | 32 | Trigger mode register |
| pend_vis | output | 32 | Guest-visible pending view |
| pend_lat | output | 32 | Pending latch view for save/restore |
| line_lvl | output | 32 | Sampled or restored line level view |

## Verification
The bench targets these collisions:
- A clear-pending write or an activation while a level line is still high. A design that ORs the level into the latch loses the split between the two views, and the latch stays set after the line drops.
- A set and a clear on the same bit in one cycle, and a rising edge that lands in the same cycle as an activation. Wrong priority here drops an interrupt.
- A level restore followed by a change on only some lines. A design that resamples every bit each cycle overwrites the restored bits, and a design that never resamples misses the changed bit.
- Trigger-mode changes, which must not touch the latch.
- Writes to unimplemented IDs and to software-generated IDs, which must leave no trace in any view.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int BANK     = 32;
  localparam int SGI_LAST = 15;

  typedef logic [BANK-1:0] bank_t;

  // Bits whose interrupt ID exists in this instance.
  function automatic bank_t impl_mask(input int base, input int num);
    bank_t m;
    for (int i = 0; i < BANK; i++) begin
      m[i] = ((base + i) < num);
    end
    return m;
  endfunction

  // Bits that own a physical line: implemented and not software-generated.
  function automatic bank_t line_mask(input int base, input int num);
    bank_t m;
    m = impl_mask(base, num);
    for (int i = 0; i < BANK; i++) begin
      if ((base + i) <= SGI_LAST) m[i] = 1'b0;
    end
    return m;
  endfunction

  // Next value of one pending latch bit: load > set > clear > hold.
  function automatic logic latch_next(input logic cur, input logic load,
                                      input logic load_val, input logic set,
                                      input logic clr);
    logic n;
    if (load)     n = load_val;
    else if (set) n = 1'b1;
    else if (clr) n = 1'b0;
    else          n = cur;
    return n;
  endfunction

  // Guest-visible pending: latch, plus live level for level-mode bits.
  function automatic bank_t visible(input bank_t lat, input bank_t lvl,
                                    input bank_t edge_mode);
    return lat | (lvl & ~edge_mode);
  endfunction

  // Level tracking: restore wins, else changed bits follow the input.
  function automatic bank_t level_next(input bank_t cur, input logic load,
                                       input bank_t load_val, input bank_t inp,
                                       input bank_t changed);
    bank_t n;
    if (load) n = load_val;
    else      n = (cur & ~changed) | (inp & changed);
    return n;
  endfunction

endpackage

// File: rtl/irq_pend_sync.sv
module irq_pend_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/irq_pend_line.sv
module irq_pend_line
  import irq_pend_pkg::*;
#(
  parameter bank_t LMASK = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  bank_t sync_in,
  input  logic  lvl_we,
  input  bank_t lvl_wdata,
  output bank_t rise,
  output bank_t chg,
  output bank_t lvl_q
);

  bank_t cur;
  bank_t prev_q;

  assign cur  = sync_in & LMASK;
  assign rise = cur & ~prev_q;
  assign chg  = cur ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lvl_q  <= '0;
    end else begin
      prev_q <= cur;
      lvl_q  <= level_next(lvl_q, lvl_we, lvl_wdata & LMASK, cur, chg);
    end
  end

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
  import irq_pend_pkg::*;
#(
  parameter bank_t IMPL = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  bank_t set_hit,
  input  bank_t clr_hit,
  input  logic  load,
  input  bank_t load_val,
  output bank_t lat_q
);

  for (genvar i = 0; i < BANK; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q[i] <= 1'b0;
      else lat_q[i] <= IMPL[i] &
                       latch_next(lat_q[i], load, load_val[i], set_hit[i], clr_hit[i]);
    end
  end

endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_pend_pkg::*;
#(
  parameter int BASE_ID     = 0,
  parameter int NUM_IRQ     = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_in,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        set_we,
  input  logic [31:0] set_data,
  input  logic        clr_we,
  input  logic [31:0] clr_data,
  input  logic [31:0] act_pulse,
  input  logic        lat_we,
  input  logic [31:0] lat_wdata,
  input  logic        lvl_we,
  input  logic [31:0] lvl_wdata,
  output logic [31:0] trig_cfg,
  output logic [31:0] pend_vis,
  output logic [31:0] pend_lat,
  output logic [31:0] line_lvl
);

  localparam bank_t IMPL  = impl_mask(BASE_ID, NUM_IRQ);
  localparam bank_t LMASK = line_mask(BASE_ID, NUM_IRQ);

  bank_t sync_q;
  bank_t rise_evt;
  bank_t chg_evt;
  bank_t set_hit;
  bank_t clr_hit;
  bank_t lvl_q;
  bank_t lat_q;
  bank_t cfg_q;

  irq_pend_sync #(.W(BANK), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in & LMASK),
    .q     (sync_q)
  );

  irq_pend_line #(.LMASK(LMASK)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_q),
    .lvl_we    (lvl_we),
    .lvl_wdata (lvl_wdata),
    .rise      (rise_evt),
    .chg       (chg_evt),
    .lvl_q     (lvl_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata & IMPL;
  end

  assign set_hit = (set_we ? set_data : '0) | (rise_evt & cfg_q);
  assign clr_hit = (clr_we ? clr_data : '0) | act_pulse;

  irq_pend_latch #(.IMPL(IMPL)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_hit  (set_hit),
    .clr_hit  (clr_hit),
    .load     (lat_we),
    .load_val (lat_wdata),
    .lat_q    (lat_q)
  );

  assign trig_cfg = cfg_q;
  assign pend_lat = lat_q;
  assign line_lvl = lvl_q;
  assign pend_vis = visible(lat_q, lvl_q, cfg_q);

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
#(
  parameter int BASE_ID = 0,
  parameter int NUM_IRQ = 28
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        set_we,
  input logic [31:0] set_data,
  input logic        clr_we,
  input logic [31:0] clr_data,
  input logic [31:0] act_pulse,
  input logic        lat_we,
  input logic [31:0] lat_wdata,
  input logic        lvl_we,
  input logic [31:0] lvl_wdata,
  input logic [31:0] trig_cfg,
  input logic [31:0] pend_vis,
  input logic [31:0] pend_lat,
  input logic [31:0] line_lvl,
  input logic [31:0] rise_evt
);

  localparam bank_t IMPL  = impl_mask(BASE_ID, NUM_IRQ);
  localparam bank_t LMASK = line_mask(BASE_ID, NUM_IRQ);

  bank_t set_eff;
  bank_t kill;
  assign set_eff = set_we ? set_data : '0;
  assign kill    = clr_data & ~set_eff & ~rise_evt;

  // R9
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vis | pend_lat | line_lvl | trig_cfg) & ~IMPL) == '0);

  // R10
  sgi_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl & ~LMASK) == '0);

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !lat_we) |=> ((pend_lat & $past(set_data & IMPL)) == $past(set_data & IMPL)));

  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !lat_we) |=> ((pend_lat & $past(kill)) == '0));

  // R3
  edge_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_cfg & (pend_vis ^ pend_lat)) == '0);

  // R4
  level_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~trig_cfg & (pend_vis ^ (pend_lat | line_lvl))) == '0);

  // R7
  lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |=> (pend_lat == $past(lat_wdata & IMPL)));

  // R8
  lvl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> (line_lvl == $past(lvl_wdata & LMASK)));

  // R11
  mode_keeps_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !lat_we && !set_we && !clr_we && act_pulse == '0 && rise_evt == '0)
      |=> $stable(pend_lat));

endmodule

bind irq_pend_tracker irq_pend_chk #(.BASE_ID(BASE_ID), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .set_we    (set_we),
  .set_data  (set_data),
  .clr_we    (clr_we),
  .clr_data  (clr_data),
  .act_pulse (act_pulse),
  .lat_we    (lat_we),
  .lat_wdata (lat_wdata),
  .lvl_we    (lvl_we),
  .lvl_wdata (lvl_wdata),
  .trig_cfg  (trig_cfg),
  .pend_vis  (pend_vis),
  .pend_lat  (pend_lat),
  .line_lvl  (line_lvl),
  .rise_evt  (rise_evt)
);

// File: tb/tb_irq_pend_tracker.sv
module tb_irq_pend_tracker;

  localparam int BASE = 0;
  localparam int NUM  = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        cfg_we = 1'b0, set_we = 1'b0, clr_we = 1'b0, lat_we = 1'b0, lvl_we = 1'b0;
  logic [31:0] cfg_wdata = '0, set_data = '0, clr_data = '0, act_pulse = '0;
  logic [31:0] lat_wdata = '0, lvl_wdata = '0;
  logic [31:0] trig_cfg, pend_vis, pend_lat, line_lvl;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_lat = '0, m_lvl = '0, m_cfg = '0, m_in = '0;

  always #4 clk = ~clk;

  irq_pend_tracker #(.BASE_ID(BASE), .NUM_IRQ(NUM), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data), .act_pulse(act_pulse),
    .lat_we(lat_we), .lat_wdata(lat_wdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .trig_cfg(trig_cfg), .pend_vis(pend_vis), .pend_lat(pend_lat), .line_lvl(line_lvl)
  );

  function automatic logic [31:0] exist_bits();
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (BASE + i < NUM) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] wired_bits();
    logic [31:0] m = exist_bits();
    for (int i = 0; i < 32; i++) if (BASE + i < 16) m[i] = 1'b0;
    return m;
  endfunction

  function automatic logic [31:0] exp_vis();
    logic [31:0] v = m_lat;
    for (int i = 0; i < 32; i++) if (!m_cfg[i] && m_lvl[i]) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " trig_cfg"}, trig_cfg, m_cfg);
    chk({tag, " pend_lat"}, pend_lat, m_lat);
    chk({tag, " line_lvl"}, line_lvl, m_lvl);
    chk({tag, " pend_vis"}, pend_vis, exp_vis());
  endtask

  // One cycle of register traffic, then model update and full check.
  task automatic op(input string tag,
                    input logic sw, input logic [31:0] sd,
                    input logic cw, input logic [31:0] cd,
                    input logic [31:0] ap,
                    input logic lw, input logic [31:0] ld,
                    input logic vw, input logic [31:0] vd,
                    input logic fw, input logic [31:0] fd);
    logic [31:0] s_eff, c_eff;
    set_we = sw; set_data = sd; clr_we = cw; clr_data = cd; act_pulse = ap;
    lat_we = lw; lat_wdata = ld; lvl_we = vw; lvl_wdata = vd;
    cfg_we = fw; cfg_wdata = fd;
    @(negedge clk);
    set_we = 0; clr_we = 0; act_pulse = '0; lat_we = 0; lvl_we = 0; cfg_we = 0;
    s_eff = sw ? sd : '0;
    c_eff = (cw ? cd : '0) | ap;
    if (lw) m_lat = ld & exist_bits();
    else    m_lat = ((m_lat & ~c_eff) | s_eff) & exist_bits();
    if (vw) m_lvl = vd & wired_bits();
    if (fw) m_cfg = fd & exist_bits();
    chk_all(tag);
  endtask

  task automatic model_input(input logic [31:0] v);
    logic [31:0] nv, ch;
    nv = v & wired_bits();
    ch = nv ^ m_in;
    m_lat = m_lat | (nv & ~m_in & m_cfg);
    m_lvl = (m_lvl & ~ch) | (nv & ch);
    m_in = nv;
  endtask

  task automatic drive_in(input string tag, input logic [31:0] v);
    irq_in = v;
    repeat (4) @(negedge clk);
    model_input(v);
    chk_all(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    // R11: mode register, unimplemented bits dropped
    op("R11 cfg all edge", 0,0, 0,0, 0, 0,0, 0,0, 1,32'hFFFF_FFFF);
    chk("R9 cfg top bits", trig_cfg, 32'h0FFF_FFFF);

    // R2 edge set by line, stays after line drops
    drive_in("R2 rise bit20", 32'h0010_0000);
    chk("R2 latch bit20", pend_lat & 32'h0010_0000, 32'h0010_0000);
    drive_in("R3 line low keeps latch", 32'h0);
    chk("R3 still pending", pend_vis & 32'h0010_0000, 32'h0010_0000);
    // R3 activation clears
    op("R3 activate bit20", 0,0, 0,0, 32'h0010_0000, 0,0, 0,0, 0,0);
    chk("R3 cleared", pend_lat & 32'h0010_0000, 32'h0);
    // R6 set and clear same bit
    op("R6 set beats clear", 1,32'h0000_0200, 1,32'h0000_0300, 0, 0,0, 0,0, 0,0);
    chk("R6 bit9 set", pend_lat & 32'h0000_0300, 32'h0000_0200);

    // R6 rising edge in same cycle as activation
    irq_in = 32'h0020_0000;
    @(negedge clk); @(negedge clk);
    act_pulse = 32'h0020_0000;
    @(negedge clk);
    act_pulse = '0;
    repeat (2) @(negedge clk);
    model_input(32'h0020_0000);
    chk("R6 rise beats activation", pend_lat & 32'h0020_0000, 32'h0020_0000);
    chk_all("R6 after collision");

    // R12 input latency: the third edge after the change
    op("R4 all level", 0,0, 1,32'hFFFF_FFFF, 0, 0,0, 0,0, 1,32'h0);
    irq_in = 32'h0024_0000;
    @(negedge clk); @(negedge clk);
    chk("R12 not yet at edge 2", line_lvl & 32'h0004_0000, 32'h0);
    @(negedge clk);
    chk("R12 level at edge 3", line_lvl & 32'h0004_0000, 32'h0004_0000);
    @(negedge clk);
    model_input(32'h0024_0000);
    chk_all("R4 level high");
    chk("R4 input never latches", pend_lat & 32'h0004_0000, 32'h0);
    chk("R4 visible from level", pend_vis & 32'h0004_0000, 32'h0004_0000);
    op("R5 clear with line high", 0,0, 1,32'h0004_0000, 32'h0004_0000, 0,0, 0,0, 0,0);
    chk("R5 still visible", pend_vis & 32'h0004_0000, 32'h0004_0000);
    drive_in("R5 line low drops", 32'h0);
    chk("R5 visible gone", pend_vis & 32'h0004_0000, 32'h0);
    op("R5 set write", 1,32'h0004_0000, 0,0, 0, 0,0, 0,0, 0,0);
    drive_in("R5 line high", 32'h0004_0000);
    drive_in("R5 line low with latch", 32'h0);
    chk("R5 latch holds visible", pend_vis & 32'h0004_0000, 32'h0004_0000);

    // R11 mode change keeps latch
    op("R11 set bit5", 1,32'h20, 0,0, 0, 0,0, 0,0, 0,0);
    op("R11 mode flip", 0,0, 0,0, 0, 0,0, 0,0, 1,32'h0000_0F20);
    chk("R11 latch kept", pend_lat & 32'h20, 32'h20);

    // R7 latch load over set/clear
    op("R7 load wins", 1,32'hFFFF_FFFF, 1,32'hFFFF_FFFF, 0, 1,32'hA5A5_5A5A, 0,0, 0,0);
    chk("R7 loaded value", pend_lat, 32'h05A5_5A5A);

    // R8 level restore, partial resample
    op("R8 restore", 0,0, 0,0, 0, 0,0, 1,32'h00FF_0000, 0,0);
    chk("R8 line view", line_lvl, 32'h00FF_0000);
    drive_in("R8 bit17 moves", 32'h0002_0000);
    chk("R8 others held", line_lvl, 32'h00FF_0000);
    drive_in("R8 bit17 low", 32'h0);
    chk("R8 bit17 follows", line_lvl, 32'h00FD_0000);

    // R9 / R10
    op("R9 high ids ignored", 1,32'hF000_0000, 0,0, 0, 0,0, 1,32'hF000_0000, 0,0);
    chk("R9 latch top", pend_lat & 32'hF000_0000, 32'h0);
    op("R10 sgi level write", 0,0, 0,0, 0, 0,0, 1,32'h0000_FFFF, 0,0);
    chk("R10 sgi line zero", line_lvl, 32'h0);
    drive_in("R10 sgi inputs", 32'h0000_FFFF);
    chk("R10 sgi lines ignored", line_lvl, 32'h0);
    op("R10 sgi set", 1,32'h0000_0008, 0,0, 0, 0,0, 0,0, 0,0);
    chk("R10 sgi latch", pend_lat & 32'h8, 32'h8);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom % 8);
      if (k == 0) drive_in("R2 R8 random input", $urandom);
      else op("R6 random op",
              1'($urandom % 2), $urandom, 1'($urandom % 2), $urandom,
              ($urandom % 3 == 0) ? $urandom : 32'h0,
              ($urandom % 9 == 0), $urandom,
              ($urandom % 7 == 0), $urandom,
              ($urandom % 6 == 0), $urandom);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule